// File: doc/BRIEF.md
# Multi-Block Flash Erase Sequencer

This block runs the complete erase procedure for a chosen set of equal-sized flash blocks. Software presents a mask with one bit per block and pulses `start`. The sequencer first writes zero to every byte of each chosen block. It then runs timed erase pulses, each followed by a verify pass over the chosen blocks. A block that reads back as fully erased leaves the mask, so the next pulse goes only to the blocks that failed. The run ends with `done`, or with `error` once the retry limit is reached.

The first pulse lasts `INIT_PULSE_US`. The pulse length doubles after each of the first few failed attempts, is never longer than `MAX_PULSE_US`, and then stays fixed. During verify, each byte gets a dummy write of 0xFF so that the array latches the address. After a wait, the byte is read and must be 0xFF. Every wait is a cycle count derived from `CLK_HZ` and rounded up, so each minimum time is always met. The flash array is reached through a plain byte port with strobes for erase mode and verify mode. A watchdog-enable output frames each pulse.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `fl_erase`, `fl_verify`, `fl_we` and `fl_re` are all low. A start with an all-zero mask raises `done` on the next clock edge, with no flash access and no erase pulse.
- R2: Before the first erase pulse, every byte of each selected block is written with 0x00. Blocks that are not selected receive no write.
- R3: The first erase pulse holds `fl_erase` high for exactly ceil(INIT_PULSE_US·CLK_HZ/1e6) cycles. `wdog_en` is high in exactly the cycles where `fl_erase` is high.
- R4: Attempts are counted from 1. After a failed verify on attempt n < DOUBLE_UNTIL, the next pulse is twice the previous one, capped at ceil(MAX_PULSE_US·CLK_HZ/1e6) cycles. From attempt DOUBLE_UNTIL onward the pulse length does not change.
- R5: During each pulse, `fl_sel` equals the set of selected blocks that have not yet passed verify, and it stays constant for the whole pulse.
- R6: After `fl_verify` rises, at least ceil(SETTLE_US·CLK_HZ/1e6) cycles pass before the first flash access of that verify pass.
- R7: Every verify read is preceded by a dummy write of 0xFF to the same address. `fl_re` comes at least ceil(READ_WAIT_US·CLK_HZ/1e6) cycles after that write. `fl_rdata` is sampled one cycle after `fl_re`.
- R8: Verify walks each remaining block from its lowest address upward. A byte other than 0xFF fails the block, and the walk moves on to the next block. A block whose bytes all read 0xFF is cleared from the mask. The run ends with `done` when the mask is empty. `done` and `error` are never high together, and both are low while `busy` is high.
- R9: If blocks still fail after attempt MAX_TRIES, `error` rises, `done` stays low, and `fl_sel` keeps the set of failing blocks.
- R10: `start` has no effect while `busy` is high. `fl_erase` and `fl_verify` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; accepted only when idle |
| block_mask_in | input | NUM_BLOCKS | Blocks to erase, one bit per block |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed; held until the next start |
| error | output | 1 | Last run hit the retry limit; held until the next start |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash byte write strobe |
| fl_re | output | 1 | Flash byte read strobe |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_re` |
| fl_erase | output | 1 | Erase mode strobe |
| fl_verify | output | 1 | Verify mode strobe |
| fl_sel | output | NUM_BLOCKS | Blocks still to be erased |
| wdog_en | output | 1 | Watchdog enable during erase pulses |

## Verification
A wrong pulse length or a wrong doubling count shows up on `fl_erase` within the pulse it affects: the high time differs from the expected 10, 20, 40, 50, 50 cycle sequence. A wrong mask shows up on `fl_sel` at the next pulse, and as a wrong number of pulses seen by each block of the flash model. A broken address walk or verify decision shows up as a run that ends too early, too late, or with `error` instead of `done`. Timing faults in verify break the settle and read-gap spacing on the flash strobes within that same pass.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int     NUM_BLOCKS    = 8,
  parameter int     BLOCK_BYTES   = 1024,
  parameter int     ADDR_W        = 16,
  parameter int     BASE_ADDR     = 0,
  parameter longint CLK_HZ        = 16_000_000,
  parameter int     INIT_PULSE_US = 6250,
  parameter int     MAX_PULSE_US  = 50000,
  parameter int     DOUBLE_UNTIL  = 4,
  parameter int     MAX_TRIES     = 602,
  parameter int     SETTLE_US     = 4,
  parameter int     READ_WAIT_US  = 2
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NUM_BLOCKS-1:0] block_mask_in,
  output logic                  busy,
  output logic                  done,
  output logic                  error,
  output logic [ADDR_W-1:0]     fl_addr,
  output logic [7:0]            fl_wdata,
  output logic                  fl_we,
  output logic                  fl_re,
  input  logic [7:0]            fl_rdata,
  output logic                  fl_erase,
  output logic                  fl_verify,
  output logic [NUM_BLOCKS-1:0] fl_sel,
  output logic                  wdog_en
);

  function automatic longint us2cyc(longint us);
    longint c;
    c = (us * CLK_HZ + 64'd999_999) / 64'd1_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

  localparam longint INIT_CYC = us2cyc(INIT_PULSE_US);
  localparam longint MAX_CYC  = us2cyc(MAX_PULSE_US);
  localparam longint SET_CYC  = us2cyc(SETTLE_US);
  localparam longint RD_CYC   = us2cyc(READ_WAIT_US);
  localparam longint TMAX     = (MAX_CYC > SET_CYC) ? ((MAX_CYC > RD_CYC) ? MAX_CYC : RD_CYC)
                                                    : ((SET_CYC > RD_CYC) ? SET_CYC : RD_CYC);
  localparam int PW = $clog2(MAX_CYC + 1);
  localparam int TW = $clog2(TMAX + 1);
  localparam int OW = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
  localparam int BW = $clog2(NUM_BLOCKS + 1);
  localparam int NW = $clog2(MAX_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_ERASE, S_SETTLE, S_VNEXT,
    S_VDUMMY, S_VWAIT, S_VREAD, S_VCHECK, S_EVAL
  } state_t;

  state_t                state;
  logic [NUM_BLOCKS-1:0] mask;
  logic [BW-1:0]         blk;
  logic [OW-1:0]         off;
  logic [TW-1:0]         timer;
  logic [PW-1:0]         pulse;
  logic [NW-1:0]         tries;
  logic                  done_r, err_r;

  logic [NUM_BLOCKS-1:0] blk_bit;
  logic                  sel_bit, last_off, last_blk;
  logic [PW:0]           dbl;
  logic [PW-1:0]         pulse_nx;

  assign blk_bit  = NUM_BLOCKS'(1) << blk;
  assign sel_bit  = |(mask & blk_bit);
  assign last_off = (off == OW'(BLOCK_BYTES - 1));
  assign last_blk = (blk == BW'(NUM_BLOCKS));
  assign dbl      = {pulse, 1'b0};
  assign pulse_nx = (int'(tries) >= DOUBLE_UNTIL) ? pulse :
                    (dbl > (PW+1)'(MAX_CYC))      ? PW'(MAX_CYC) : dbl[PW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      mask   <= '0;
      blk    <= '0;
      off    <= '0;
      timer  <= '0;
      pulse  <= PW'(INIT_CYC);
      tries  <= '0;
      done_r <= 1'b0;
      err_r  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done_r <= 1'b0;
          err_r  <= 1'b0;
          if (block_mask_in == '0) done_r <= 1'b1;
          else begin
            mask  <= block_mask_in;
            blk   <= '0;
            off   <= '0;
            pulse <= PW'(INIT_CYC);
            tries <= NW'(1);
            state <= S_PRE;
          end
        end
        S_PRE: begin
          if (last_blk) begin
            timer <= TW'(pulse) - TW'(1);
            state <= S_ERASE;
          end else if (sel_bit && !last_off) off <= off + 1'b1;
          else begin
            off <= '0;
            blk <= blk + 1'b1;
          end
        end
        S_ERASE: begin
          if (timer == '0) begin
            timer <= TW'(SET_CYC - 1);
            blk   <= '0;
            state <= S_SETTLE;
          end else timer <= timer - 1'b1;
        end
        S_SETTLE: begin
          if (timer == '0) state <= S_VNEXT;
          else timer <= timer - 1'b1;
        end
        S_VNEXT: begin
          if (last_blk) state <= S_EVAL;
          else if (sel_bit) begin
            off   <= '0;
            state <= S_VDUMMY;
          end else blk <= blk + 1'b1;
        end
        S_VDUMMY: begin
          timer <= TW'(RD_CYC - 1);
          state <= S_VWAIT;
        end
        S_VWAIT: begin
          if (timer == '0) state <= S_VREAD;
          else timer <= timer - 1'b1;
        end
        S_VREAD: state <= S_VCHECK;
        S_VCHECK: begin
          if (fl_rdata != 8'hFF) begin
            blk   <= blk + 1'b1;
            state <= S_VNEXT;
          end else if (last_off) begin
            mask  <= mask & ~blk_bit;
            blk   <= blk + 1'b1;
            state <= S_VNEXT;
          end else begin
            off   <= off + 1'b1;
            state <= S_VDUMMY;
          end
        end
        S_EVAL: begin
          if (mask == '0) begin
            done_r <= 1'b1;
            state  <= S_IDLE;
          end else if (tries >= NW'(MAX_TRIES)) begin
            err_r <= 1'b1;
            state <= S_IDLE;
          end else begin
            pulse <= pulse_nx;
            tries <= tries + 1'b1;
            timer <= TW'(pulse_nx) - TW'(1);
            state <= S_ERASE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = done_r;
  assign error     = err_r;
  assign fl_erase  = (state == S_ERASE);
  assign wdog_en   = (state == S_ERASE);
  assign fl_verify = (state == S_SETTLE) || (state == S_VNEXT) || (state == S_VDUMMY) ||
                     (state == S_VWAIT)  || (state == S_VREAD) || (state == S_VCHECK);
  assign fl_we     = ((state == S_PRE) && sel_bit) || (state == S_VDUMMY);
  assign fl_re     = (state == S_VREAD);
  assign fl_wdata  = (state == S_VDUMMY) ? 8'hFF : 8'h00;
  assign fl_sel    = mask;
  assign fl_addr   = ADDR_W'(BASE_ADDR) + ADDR_W'(blk) * ADDR_W'(BLOCK_BYTES) + ADDR_W'(off);

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int     NUM_BLOCKS   = 8,
  parameter longint CLK_HZ       = 16_000_000,
  parameter int     SETTLE_US    = 4,
  parameter int     READ_WAIT_US = 2
)(
  input logic                  clk,
  input logic                  rst,
  input logic                  busy,
  input logic                  done,
  input logic                  error,
  input logic                  fl_we,
  input logic                  fl_re,
  input logic [7:0]            fl_wdata,
  input logic                  fl_erase,
  input logic                  fl_verify,
  input logic                  wdog_en,
  input logic [NUM_BLOCKS-1:0] fl_sel
);

  function automatic longint us2cyc(longint us);
    longint c;
    c = (us * CLK_HZ + 64'd999_999) / 64'd1_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

  localparam longint SET_CYC = us2cyc(SETTLE_US);
  localparam longint RD_CYC  = us2cyc(READ_WAIT_US);

  logic [15:0] since_v, since_we;
  logic        accessed;

  always_ff @(posedge clk) begin
    if (rst || !fl_verify) begin
      since_v  <= '0;
      accessed <= 1'b0;
    end else begin
      if (since_v != 16'hFFFF) since_v <= since_v + 1'b1;
      if (fl_we || fl_re) accessed <= 1'b1;
    end
    if (rst || fl_we) since_we <= '0;
    else if (since_we != 16'hFFFF) since_we <= since_we + 1'b1;
  end

  // R10
  modes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(fl_erase && fl_verify));

  // R3
  wdog_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_erase) |-> wdog_en);

  // R3
  wdog_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_erase) |-> !wdog_en);

  // R5
  sel_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (fl_erase && $past(fl_erase)) |-> $stable(fl_sel));

  // R5
  sel_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    fl_erase |-> (fl_sel != '0));

  // R2
  prewrite_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fl_we && !fl_verify) |-> (fl_wdata == 8'h00));

  // R7
  dummy_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (fl_we && fl_verify) |-> (fl_wdata == 8'hFF));

  // R6
  settle_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (fl_verify && (fl_we || fl_re) && !accessed) |-> (longint'(since_v) >= SET_CYC));

  // R7
  read_gap_chk: assert property (@(posedge clk) disable iff (rst)
    fl_re |-> (longint'(since_we) >= RD_CYC));

  // R8
  result_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && error) && !(busy && (done || error)));

endmodule

bind flash_erase_seq flash_erase_seq_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .CLK_HZ(CLK_HZ),
  .SETTLE_US(SETTLE_US), .READ_WAIT_US(READ_WAIT_US)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .error(error),
  .fl_we(fl_we), .fl_re(fl_re), .fl_wdata(fl_wdata), .fl_erase(fl_erase),
  .fl_verify(fl_verify), .wdog_en(wdog_en), .fl_sel(fl_sel)
);

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int BB = 4;
  localparam int BASE = 16;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [NB-1:0] block_mask_in = '0;
  logic          busy, done, error, fl_we, fl_re, fl_erase, fl_verify, wdog_en;
  logic [7:0]    fl_addr, fl_wdata;
  logic [7:0]    fl_rdata = 8'h00;
  logic [NB-1:0] fl_sel;

  flash_erase_seq #(
    .NUM_BLOCKS(NB), .BLOCK_BYTES(BB), .ADDR_W(8), .BASE_ADDR(BASE),
    .CLK_HZ(1_000_000), .INIT_PULSE_US(10), .MAX_PULSE_US(50),
    .DOUBLE_UNTIL(4), .MAX_TRIES(6), .SETTLE_US(4), .READ_WAIT_US(2)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .block_mask_in(block_mask_in),
    .busy(busy), .done(done), .error(error), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata),
    .fl_erase(fl_erase), .fl_verify(fl_verify), .fl_sel(fl_sel), .wdog_en(wdog_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  logic [7:0]    mem [0:255];
  int            need [NB];
  int            hits [NB];
  int            plen [16];
  logic [NB-1:0] slog [16];
  int            npulse = 0, cur_len = 0;
  logic          prev_er = 1'b0, first_pulse = 1'b0, pre_ok = 1'b1;
  int            v_cnt = 0, we_cnt = 0;
  logic          v_acc = 1'b0;
  int            settle_bad = 0, gap_bad = 0, dummy_bad = 0, wd_bad = 0, both_bad = 0;

  always @(posedge clk) begin
    if (!rst) begin
      if (fl_we && !fl_verify) mem[fl_addr] = fl_wdata;
      if (fl_re) fl_rdata <= mem[fl_addr];
      if (wdog_en !== fl_erase) wd_bad++;
      if (fl_erase && fl_verify) both_bad++;
      if (fl_we && fl_verify && fl_wdata != 8'hFF) dummy_bad++;
      if (fl_re && we_cnt < 2) gap_bad++;
      we_cnt = fl_we ? 0 : we_cnt + 1;
      if (fl_verify) begin
        if ((fl_we || fl_re) && !v_acc && v_cnt < 4) settle_bad++;
        if (fl_we || fl_re) v_acc = 1'b1;
        v_cnt++;
      end else begin
        v_cnt = 0;
        v_acc = 1'b0;
      end
      if (fl_erase && !prev_er) begin
        if (first_pulse) begin
          for (int b = 0; b < NB; b++)
            if (fl_sel[b])
              for (int o = 0; o < BB; o++)
                if (mem[BASE + b*BB + o] != 8'h00) pre_ok = 1'b0;
          first_pulse = 1'b0;
        end
        if (npulse < 16) slog[npulse] = fl_sel;
        for (int b = 0; b < NB; b++)
          if (fl_sel[b]) begin
            hits[b]++;
            for (int o = 0; o < BB; o++)
              mem[BASE + b*BB + o] = (hits[b] >= need[b] || o != BB-1) ? 8'hFF : 8'h00;
          end
        cur_len = 0;
      end
      if (fl_erase) cur_len++;
      if (!fl_erase && prev_er) begin
        if (npulse < 16) plen[npulse] = cur_len;
        npulse++;
      end
      prev_er = fl_erase;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prep(input int n0, input int n1, input int n2, input int n3);
    need[0] = n0; need[1] = n1; need[2] = n2; need[3] = n3;
    for (int b = 0; b < NB; b++) hits[b] = 0;
    for (int a = 0; a < 256; a++) mem[a] = 8'h5A;
    npulse = 0;
    first_pulse = 1'b1;
    pre_ok = 1'b1;
  endtask

  task automatic launch(input logic [NB-1:0] m);
    @(negedge clk);
    block_mask_in = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !error && !fl_erase && !fl_verify && !fl_we && !fl_re,
        "R1 reset idle", int'({busy, done, error, fl_erase, fl_verify, fl_we, fl_re}), 0);
  endtask

  task automatic t_zero_mask;
    prep(1, 1, 1, 1);
    launch(4'b0000);
    chk(done && !error && !busy, "R1 zero mask done", int'({done, error, busy}), 4);
    chk(npulse == 0, "R1 zero mask no pulse", npulse, 0);
    chk(mem[BASE] == 8'h5A, "R1 zero mask no write", int'(mem[BASE]), 8'h5A);
  endtask

  task automatic t_single;
    prep(1, 1, 1, 1);
    launch(4'b0001);
    chk(done && !error, "R8 single done", int'({done, error}), 2);
    chk(npulse == 1, "R3 single pulse count", npulse, 1);
    chk(plen[0] == 10, "R3 first pulse length", plen[0], 10);
    chk(pre_ok, "R2 prewrite zero", int'(pre_ok), 1);
    chk(slog[0] == 4'b0001, "R5 single sel", int'(slog[0]), 1);
    chk(mem[BASE + 4] == 8'h5A, "R2 unselected untouched", int'(mem[BASE + 4]), 8'h5A);
  endtask

  task automatic t_multi;
    prep(1, 3, 2, 1);
    launch(4'b0111);
    chk(done && !error, "R8 multi done", int'({done, error}), 2);
    chk(npulse == 3, "R8 multi pulse count", npulse, 3);
    chk(plen[1] == 20 && plen[2] == 40, "R4 doubling", plen[1] * 100 + plen[2], 2040);
    chk(slog[0] == 4'b0111, "R5 sel pulse1", int'(slog[0]), 7);
    chk(slog[1] == 4'b0110, "R5 sel pulse2", int'(slog[1]), 6);
    chk(slog[2] == 4'b0010, "R5 sel pulse3", int'(slog[2]), 2);
    chk(hits[0] == 1 && hits[1] == 3 && hits[2] == 2,
        "R8 per-block pulses", hits[0] * 100 + hits[1] * 10 + hits[2], 132);
    chk(pre_ok, "R2 multi prewrite", int'(pre_ok), 1);
    chk(mem[BASE + 12] == 8'h5A && hits[3] == 0, "R2 block3 untouched", int'(mem[BASE + 12]), 8'h5A);
  endtask

  task automatic t_long;
    prep(1, 1, 1, 5);
    launch(4'b1000);
    chk(done && npulse == 5, "R4 long done", npulse, 5);
    chk(plen[3] == 50, "R4 clamp at max", plen[3], 50);
    chk(plen[4] == 50, "R4 fixed after limit", plen[4], 50);
  endtask

  task automatic t_error;
    prep(1, 1, 100, 1);
    launch(4'b0100);
    chk(error && !done, "R9 error raised", int'({error, done}), 2);
    chk(npulse == 6, "R9 retry limit", npulse, 6);
    chk(fl_sel == 4'b0100, "R9 failing mask kept", int'(fl_sel), 4);
    chk(plen[5] == 50, "R4 sixth pulse", plen[5], 50);
  endtask

  task automatic t_busy_start;
    prep(2, 1, 1, 1);
    @(negedge clk);
    block_mask_in = 4'b0001;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    block_mask_in = 4'b1111;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk(done && npulse == 2, "R10 start ignored count", npulse, 2);
    chk(slog[1] == 4'b0001 && hits[3] == 0, "R10 start ignored mask", int'(slog[1]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_zero_mask;
    t_single;
    t_multi;
    t_long;
    t_error;
    t_busy_start;
    chk(settle_bad == 0, "R6 settle wait", settle_bad, 0);
    chk(gap_bad == 0, "R7 read gap", gap_bad, 0);
    chk(dummy_bad == 0, "R7 dummy data", dummy_bad, 0);
    chk(wd_bad == 0, "R3 watchdog frame", wd_bad, 0);
    chk(both_bad == 0, "R10 modes exclusive", both_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule